// File: doc/BRIEF.md
# Registered Programmable Sum-of-Products Array

This block is a small logic array of the fuse-programmed kind. Every output has its own group of product terms. Each term is an AND of any chosen mix of array inputs, taken in true or inverted form, and the output ORs its group together. The array sees eight dedicated inputs plus eight feedback lines, one per output. A feedback line carries the output's register when that output is registered, and the sampled pin value when it is combinational.

A per-output mode bit decides how the OR result leaves the block:
- **Registered mode:** the result is captured on the rising clock edge. The pin is driven while the shared active-low enable is low.
- **Combinational mode:** the result passes straight to the pin. A ninth product term decides when that pin is driven.

Configuration arrives one bit at a time over a valid/ready stream. The same map can be streamed back out over a second valid/ready stream. A lock command hides the map from readback and freezes it until an erase. A preload input writes the registers directly for test. Reset clears everything, and every pin stays undriven until a complete map has been loaded.

Top module: `pla_array`

## Requirements
- R1: Product terms follow three rules. A term with no connection set is 1. A term connected to both the true and the complement column of any one input is 0. Otherwise the term is the AND of its connected literals.
- R2: Each output's sum is the OR of its eight logic terms, t=0..7.
- R3: On each rising edge every output register loads its sum. Array input j<8 is `ded_in[j]`. Array input 8+o is output o's register when mode bit o is 1, and `pin_in[o]` otherwise.
- R4: A registered output drives (`pin_oe`=1) exactly while `oe_n` is 0. A combinational output drives exactly while its term t=8 is 1. `pin_out` reads 0 on an undriven pin.
- R5: While `pl_en` is 1, the rising edge loads `pl_data` into the registers instead of the sums.
- R6: Reset clears the registers, the map, the lock and the map-valid state. `pin_oe` stays 0 until the last bit of a full map has been accepted. Erase also returns the block to this state.
- R7: Map bit ((o*9+t)*32 + 2*j + p) connects array input j to term t of output o. Here p=0 selects the true column and p=1 the complement column, and a bit value of 1 means connected. Bit 2304+o is the mode of output o, where 1 means registered. Bits are accepted in ascending index order on `cfg_valid && cfg_ready`. Accepting bit 0 clears map-valid, and accepting bit 2311 sets it.
- R8: A one-cycle `rb_start` pulse, given while idle, streams all 2312 bits in index order on `rb_valid`/`rb_data`. `rb_last` marks the final bit. The stream advances only on `rb_ready`. While it runs, `cfg_ready` is 0.
- R9: `lock_req` sets the lock only while the map is valid. While locked, readback returns 0 for every bit and configuration bits are dropped. Erase clears the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ded_in | input | 8 | Dedicated array inputs |
| pin_in | input | 8 | Sampled pin values, used as feedback for combinational outputs |
| oe_n | input | 1 | Shared active-low enable for registered outputs |
| pl_en | input | 1 | Register preload strobe |
| pl_data | input | 8 | Preload value |
| cfg_valid | input | 1 | Configuration bit valid |
| cfg_ready | output | 1 | Configuration bit can be accepted |
| cfg_bit | input | 1 | Configuration bit |
| erase | input | 1 | Full erase command |
| lock_req | input | 1 | Set the security lock |
| rb_start | input | 1 | Begin readback |
| rb_valid | output | 1 | Readback bit valid |
| rb_ready | input | 1 | Readback consumer ready |
| rb_data | output | 1 | Readback bit |
| rb_last | output | 1 | Final readback bit |
| pin_out | output | 8 | Output pin values |
| pin_oe | output | 8 | Output pin drive enables |

## Verification
The hold property on the readback stream assumes two things about a stall cycle: no erase and no lock request. Either of those may legitimately change or abort the stream. The stimulus raises lock and erase only while the stream is idle.

The preload and drive properties assume that `pl_data` and `oe_n` change only between clock edges. The bench drives every input just after a rising edge.

Configuration bits are offered during readback only to confirm that they are refused. Array inputs are randomised freely, because the block has no constraint on them.

// File: rtl/pla_pkg.sv
package pla_pkg;
  localparam int unsigned PLA_DED  = 8;
  localparam int unsigned PLA_OUT  = 8;
  localparam int unsigned PLA_TERM = 8;

  typedef enum logic [0:0] {RB_IDLE = 1'b0, RB_SEND = 1'b1} rb_state_t;
endpackage

// File: rtl/pla_term.sv
module pla_term #(
  parameter int unsigned N_COL = 16
) (
  input  logic [N_COL-1:0]   x,
  input  logic [2*N_COL-1:0] link,
  output logic               hit
);
  // Open links leave the term high; a link to a literal that is false pulls it low.
  always_comb begin
    hit = 1'b1;
    for (int j = 0; j < int'(N_COL); j++) begin
      if (link[2*j]   && !x[j]) hit = 1'b0;
      if (link[2*j+1] &&  x[j]) hit = 1'b0;
    end
  end
endmodule

// File: rtl/pla_and_or.sv
module pla_and_or #(
  parameter int unsigned N_IN   = 16,
  parameter int unsigned N_OUT  = 8,
  parameter int unsigned N_TERM = 8,
  localparam int unsigned TPO   = N_TERM + 1,
  localparam int unsigned ROW   = 2 * N_IN,
  localparam int unsigned N_TB  = N_OUT * TPO * ROW
) (
  input  logic [N_IN-1:0]  x,
  input  logic [N_TB-1:0]  links,
  output logic [N_OUT-1:0] sum,
  output logic [N_OUT-1:0] oe_term
);
  logic [N_OUT*TPO-1:0] hits;

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    for (genvar t = 0; t < TPO; t++) begin : g_term
      pla_term #(.N_COL(N_IN)) u_term (
        .x    (x),
        .link (links[(o*TPO+t)*ROW +: ROW]),
        .hit  (hits[o*TPO+t])
      );
    end
    assign sum[o]     = |hits[o*TPO +: N_TERM];
    assign oe_term[o] = hits[o*TPO + N_TERM];
  end
endmodule

// File: rtl/pla_cfg_store.sv
module pla_cfg_store
  import pla_pkg::*;
#(
  parameter int unsigned N_BITS = 2312,
  localparam int unsigned PW    = $clog2(N_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic              cfg_bit,
  input  logic              erase,
  input  logic              lock_req,
  input  logic              rb_start,
  output logic              rb_valid,
  input  logic              rb_ready,
  output logic              rb_data,
  output logic              rb_last,
  output logic [N_BITS-1:0] map,
  output logic              cfg_ok,
  output logic              locked
);
  localparam logic [PW-1:0] LAST = PW'(N_BITS - 1);

  rb_state_t     rb_state;
  logic [PW-1:0] wptr;
  logic [PW-1:0] rptr;
  logic          take;

  assign cfg_ready = (rb_state == RB_IDLE);
  assign take      = cfg_valid && cfg_ready && !locked;
  assign rb_valid  = (rb_state == RB_SEND);
  assign rb_data   = rb_valid && !locked && map[rptr];
  assign rb_last   = rb_valid && (rptr == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map      <= '0;
      wptr     <= '0;
      rptr     <= '0;
      cfg_ok   <= 1'b0;
      locked   <= 1'b0;
      rb_state <= RB_IDLE;
    end else if (erase) begin
      map      <= '0;
      wptr     <= '0;
      rptr     <= '0;
      cfg_ok   <= 1'b0;
      locked   <= 1'b0;
      rb_state <= RB_IDLE;
    end else begin
      if (take) begin
        map[wptr] <= cfg_bit;
        if (wptr == LAST) begin
          wptr   <= '0;
          cfg_ok <= 1'b1;
        end else begin
          if (wptr == '0) cfg_ok <= 1'b0;
          wptr <= wptr + 1'b1;
        end
      end
      if (lock_req && cfg_ok) locked <= 1'b1;
      if (rb_state == RB_IDLE) begin
        if (rb_start) begin
          rb_state <= RB_SEND;
          rptr     <= '0;
        end
      end else if (rb_ready) begin
        if (rptr == LAST) rb_state <= RB_IDLE;
        else              rptr     <= rptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pla_out_cells.sv
module pla_out_cells #(
  parameter int unsigned N_OUT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_OUT-1:0] sum,
  input  logic [N_OUT-1:0] oe_term,
  input  logic [N_OUT-1:0] mode,
  input  logic             cfg_ok,
  input  logic             oe_n,
  input  logic             pl_en,
  input  logic [N_OUT-1:0] pl_data,
  output logic [N_OUT-1:0] q,
  output logic [N_OUT-1:0] pin_out,
  output logic [N_OUT-1:0] pin_oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (pl_en) q <= pl_data;
    else            q <= sum;
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_cell
    assign pin_oe[o]  = cfg_ok && (mode[o] ? !oe_n : oe_term[o]);
    assign pin_out[o] = pin_oe[o] && (mode[o] ? q[o] : sum[o]);
  end
endmodule

// File: rtl/pla_array.sv
module pla_array
  import pla_pkg::*;
#(
  parameter int unsigned N_DED  = PLA_DED,
  parameter int unsigned N_OUT  = PLA_OUT,
  parameter int unsigned N_TERM = PLA_TERM,
  localparam int unsigned N_IN  = N_DED + N_OUT,
  localparam int unsigned TPO   = N_TERM + 1,
  localparam int unsigned ROW   = 2 * N_IN,
  localparam int unsigned N_TB  = N_OUT * TPO * ROW,
  localparam int unsigned N_BITS = N_TB + N_OUT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DED-1:0] ded_in,
  input  logic [N_OUT-1:0] pin_in,
  input  logic             oe_n,
  input  logic             pl_en,
  input  logic [N_OUT-1:0] pl_data,
  input  logic             cfg_valid,
  output logic             cfg_ready,
  input  logic             cfg_bit,
  input  logic             erase,
  input  logic             lock_req,
  input  logic             rb_start,
  output logic             rb_valid,
  input  logic             rb_ready,
  output logic             rb_data,
  output logic             rb_last,
  output logic [N_OUT-1:0] pin_out,
  output logic [N_OUT-1:0] pin_oe
);
  logic [N_BITS-1:0] map_w;
  logic              cfg_ok_w;
  logic              locked_w;
  logic [N_OUT-1:0]  mode_w;
  logic [N_OUT-1:0]  q_w;
  logic [N_OUT-1:0]  fb_w;
  logic [N_OUT-1:0]  sum_w;
  logic [N_OUT-1:0]  oe_term_w;

  pla_cfg_store #(.N_BITS(N_BITS)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_valid (cfg_valid),
    .cfg_ready (cfg_ready),
    .cfg_bit   (cfg_bit),
    .erase     (erase),
    .lock_req  (lock_req),
    .rb_start  (rb_start),
    .rb_valid  (rb_valid),
    .rb_ready  (rb_ready),
    .rb_data   (rb_data),
    .rb_last   (rb_last),
    .map       (map_w),
    .cfg_ok    (cfg_ok_w),
    .locked    (locked_w)
  );

  assign mode_w = map_w[N_TB +: N_OUT];

  for (genvar o = 0; o < N_OUT; o++) begin : g_fb
    assign fb_w[o] = mode_w[o] ? q_w[o] : pin_in[o];
  end

  pla_and_or #(.N_IN(N_IN), .N_OUT(N_OUT), .N_TERM(N_TERM)) u_plane (
    .x       ({fb_w, ded_in}),
    .links   (map_w[N_TB-1:0]),
    .sum     (sum_w),
    .oe_term (oe_term_w)
  );

  pla_out_cells #(.N_OUT(N_OUT)) u_cells (
    .clk     (clk),
    .rst_n   (rst_n),
    .sum     (sum_w),
    .oe_term (oe_term_w),
    .mode    (mode_w),
    .cfg_ok  (cfg_ok_w),
    .oe_n    (oe_n),
    .pl_en   (pl_en),
    .pl_data (pl_data),
    .q       (q_w),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
  );
endmodule

// File: rtl/pla_array_chk.sv
module pla_array_chk #(
  parameter int unsigned N_OUT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             erase,
  input logic             lock_req,
  input logic             pl_en,
  input logic [N_OUT-1:0] pl_data,
  input logic             oe_n,
  input logic             cfg_ready,
  input logic             rb_valid,
  input logic             rb_ready,
  input logic             rb_data,
  input logic             rb_last,
  input logic [N_OUT-1:0] pin_oe,
  input logic [N_OUT-1:0] q,
  input logic [N_OUT-1:0] mode,
  input logic             locked
);
  // R6
  dark_after_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> (pin_oe == '0));

  // R5
  preload_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pl_en |=> (q == $past(pl_data)));

  // R8
  rb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_valid && !rb_ready && !erase && !lock_req) |=>
      (rb_valid && $stable(rb_data) && $stable(rb_last)));

  // R7
  busy_blocks_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rb_valid |-> !cfg_ready);

  // R9
  locked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && rb_valid) |-> !rb_data);

  // R4
  reg_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> ((pin_oe & mode) == '0));
endmodule

bind pla_array pla_array_chk #(.N_OUT(N_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .erase     (erase),
  .lock_req  (lock_req),
  .pl_en     (pl_en),
  .pl_data   (pl_data),
  .oe_n      (oe_n),
  .cfg_ready (cfg_ready),
  .rb_valid  (rb_valid),
  .rb_ready  (rb_ready),
  .rb_data   (rb_data),
  .rb_last   (rb_last),
  .pin_oe    (pin_oe),
  .q         (q_w),
  .mode      (mode_w),
  .locked    (locked_w)
);

// File: tb/sim_pla_array.sv
`timescale 1ns/1ps
module sim_pla_array;
  localparam int NB = 2312;
  localparam int NTB = 2304;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] ded_in = '0, pin_in = '0, pl_data = '0;
  logic oe_n = 1'b1, pl_en = 1'b0, cfg_valid = 1'b0, cfg_bit = 1'b0;
  logic erase = 1'b0, lock_req = 1'b0, rb_start = 1'b0, rb_ready = 1'b1;
  logic cfg_ready, rb_valid, rb_data, rb_last;
  logic [7:0] pin_out, pin_oe;

  int errors = 0, checks = 0;

  bit m_map [NB];
  bit pat [NB];
  bit [7:0] m_q;
  bit m_ok, m_lock, m_busy;
  int m_wptr, m_rptr;

  always #4 clk = ~clk;

  pla_array u0 (
    .clk(clk), .rst_n(rst_n), .ded_in(ded_in), .pin_in(pin_in), .oe_n(oe_n),
    .pl_en(pl_en), .pl_data(pl_data), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_bit(cfg_bit), .erase(erase), .lock_req(lock_req), .rb_start(rb_start),
    .rb_valid(rb_valid), .rb_ready(rb_ready), .rb_data(rb_data), .rb_last(rb_last),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int bi(int o, int t, int j, int p);
    return (o*9 + t)*32 + 2*j + p;
  endfunction

  function automatic bit m_term(int o, int t);
    for (int j = 0; j < 16; j++) begin
      bit xv;
      if (j < 8) xv = ded_in[j];
      else       xv = m_map[NTB + j - 8] ? m_q[j-8] : pin_in[j-8];
      if (m_map[bi(o,t,j,0)] && !xv) return 1'b0;
      if (m_map[bi(o,t,j,1)] &&  xv) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic bit m_sum(int o);
    for (int t = 0; t < 8; t++) if (m_term(o,t)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NB; i++) m_map[i] = 1'b0;
    m_q = '0; m_ok = 0; m_lock = 0; m_busy = 0; m_wptr = 0; m_rptr = 0;
  endtask

  // One clock: compare outputs mid-cycle, then advance the reference model across the edge.
  task automatic step(string req);
    bit [7:0] e_oe, e_out, n_q;
    bit n_ok, n_lock, n_busy, wr, wbit;
    int n_wptr, n_rptr, widx;
    @(negedge clk); #1;
    for (int o = 0; o < 8; o++) begin
      bit md = m_map[NTB+o];
      bit s = m_sum(o);
      e_oe[o]  = m_ok && (md ? !oe_n : m_term(o,8));
      e_out[o] = e_oe[o] && (md ? m_q[o] : s);
      n_q[o]   = pl_en ? pl_data[o] : s;
    end
    chk(req, "pin_oe", 32'(pin_oe), 32'(e_oe));
    chk(req, "pin_out", 32'(pin_out), 32'(e_out));
    chk("R7", "cfg_ready", 32'(cfg_ready), 32'(!m_busy));
    chk("R8", "rb_valid", 32'(rb_valid), 32'(m_busy));
    if (m_busy) begin
      chk("R8/R9", "rb_data", 32'(rb_data), 32'(!m_lock && m_map[m_rptr]));
      chk("R8", "rb_last", 32'(rb_last), 32'(m_rptr == NB-1));
    end
    n_ok = m_ok; n_lock = m_lock; n_busy = m_busy; n_wptr = m_wptr; n_rptr = m_rptr;
    wr = 0; widx = 0; wbit = 0;
    if (!erase) begin
      if (cfg_valid && !m_busy && !m_lock) begin
        wr = 1; widx = m_wptr; wbit = cfg_bit;
        if (m_wptr == NB-1) begin n_wptr = 0; n_ok = 1; end
        else begin if (m_wptr == 0) n_ok = 0; n_wptr = m_wptr + 1; end
      end
      if (lock_req && m_ok) n_lock = 1;
      if (!m_busy) begin
        if (rb_start) begin n_busy = 1; n_rptr = 0; end
      end else if (rb_ready) begin
        if (m_rptr == NB-1) n_busy = 0; else n_rptr = m_rptr + 1;
      end
    end
    @(posedge clk); #1;
    if (erase) begin
      bit [7:0] keep_q = n_q;
      model_reset();
      m_q = keep_q;
    end else begin
      if (wr) m_map[widx] = wbit;
      m_ok = n_ok; m_lock = n_lock; m_busy = n_busy; m_wptr = n_wptr; m_rptr = n_rptr;
      m_q = n_q;
    end
  endtask

  task automatic load(string req);
    for (int i = 0; i < NB; i++) begin
      cfg_valid = 1'b1; cfg_bit = pat[i];
      step(req);
    end
    cfg_valid = 1'b0;
  endtask

  task automatic readback(string req);
    rb_start = 1'b1; step(req); rb_start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      cfg_valid = 1'b1; cfg_bit = 1'b1; rb_ready = 1'b0;
      step("R7");
    end
    cfg_valid = 1'b0;
    while (m_busy) begin
      rb_ready = ($urandom_range(0,3) != 0);
      step(req);
    end
    rb_ready = 1'b1;
  endtask

  task automatic run_rand(int n, string req);
    for (int k = 0; k < n; k++) begin
      ded_in = 8'($urandom); pin_in = 8'($urandom);
      oe_n = ($urandom_range(0,3) == 0);
      pl_en = ($urandom_range(0,9) == 0); pl_data = 8'($urandom);
      step(req);
    end
    pl_en = 1'b0; oe_n = 1'b0;
  endtask

  task automatic kill(int o, int t);
    pat[bi(o,t,0,0)] = 1; pat[bi(o,t,0,1)] = 1;
  endtask

  task automatic build_a();
    for (int i = 0; i < NB; i++) pat[i] = 0;
    for (int o = 0; o < 8; o++) for (int t = 1; t < 8; t++) kill(o,t);
    pat[bi(0,0,0,0)] = 1; pat[bi(0,0,1,0)] = 1;              // out0 = in0 & in1
    pat[bi(1,0,9,1)] = 1;                                    // out1 toggles
    pat[bi(2,0,2,0)] = 1; pat[bi(2,1,3,0)] = 1; pat[bi(2,1,4,1)] = 1;
    pat[bi(2,1,0,0)] = 0; pat[bi(2,1,0,1)] = 0;              // term 1 used on out2
    pat[bi(2,8,5,0)] = 1;                                    // out2 driven by in5
    pat[bi(4,0,12,1)] = 1; kill(4,8);                        // out4 never driven
    pat[bi(5,0,6,0)] = 1; pat[bi(5,0,7,1)] = 1;
    pat[bi(5,1,0,0)] = 0; pat[bi(5,1,0,1)] = 0;
    pat[bi(5,1,6,1)] = 1; pat[bi(5,1,7,0)] = 1;              // out5 = in6 ^ in7
    kill(6,0);                                               // out6 constant 0
    pat[bi(7,0,8,0)] = 1;                                    // out7 = q0
    pat[NTB+0] = 1; pat[NTB+1] = 1; pat[NTB+5] = 1; pat[NTB+6] = 1; pat[NTB+7] = 1;
  endtask

  task automatic build_b();
    for (int i = 0; i < NTB; i++) pat[i] = ($urandom_range(0,15) == 0);
    for (int o = 0; o < 8; o++) pat[NTB+o] = $urandom_range(0,1);
  endtask

  initial begin
    #(8*200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R6", "reset pin_oe", 32'(pin_oe), 32'h0);
    chk("R6", "reset cfg_ready", 32'(cfg_ready), 32'h1);
    chk("R6", "reset rb_valid", 32'(rb_valid), 32'h0);
    rst_n = 1'b1;
    oe_n = 1'b0;
    step("R6");

    build_a();
    load("R6/R7");
    chk("R6", "map valid drives", 32'(pin_oe[3]), 32'h1);

    ded_in = 8'h03; step("R3");
    chk("R3", "out0 and", 32'(pin_out[0]), 32'h1);
    chk("R1", "open term high", 32'(pin_out[3]), 32'h1);
    chk("R1", "conflict term low", 32'(pin_out[6]), 32'h0);
    chk("R4", "comb oe term", 32'(pin_oe[4]), 32'h0);
    ded_in = 8'h18; step("R2");
    chk("R2", "out2 or term1", 32'({pin_oe[2], pin_out[2]}), 32'h0);
    ded_in = 8'h28; step("R2");
    chk("R2", "out2 or term1 driven", 32'({pin_oe[2], pin_out[2]}), 32'h3);

    pl_en = 1'b1; pl_data = 8'hA5; step("R5"); pl_en = 1'b0;
    chk("R5", "preload", 32'(pin_out & 8'hE3), 32'hA1);
    oe_n = 1'b1; step("R4");
    chk("R4", "reg undriven", 32'(pin_oe & 8'hE3), 32'h0);
    oe_n = 1'b0;

    run_rand(400, "R1/R2/R3/R4/R5");
    readback("R8");

    lock_req = 1'b1; step("R9"); lock_req = 1'b0;
    readback("R9");
    build_b();
    load("R9");
    run_rand(100, "R9");

    erase = 1'b1; step("R6"); erase = 1'b0;
    step("R6");
    chk("R6", "erase dark", 32'(pin_oe), 32'h0);
    load("R7");
    readback("R8");
    run_rand(400, "R1/R2/R3/R4/R5");

    @(negedge clk); rst_n = 1'b0; #2;
    chk("R6", "async reset dark", 32'(pin_oe), 32'h0);
    model_reset();
    @(posedge clk); #1; rst_n = 1'b1;
    step("R6");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule